// File: doc/BRIEF.md
# UART FIFO-Threshold Interrupt Controller

This block merges the interrupt sources of a UART with receive and transmit FIFOs into one active-low interrupt line. It watches the two FIFO occupancy counts against programmable trigger levels. It also latches the event sources that come from the framing logic: transmit underrun, transmit completion, status-FIFO errors and received end-of-frame. The highest-priority pending and enabled source is reported as a one-hot identification vector.

Each trigger level comes from one of two places. A 4-bit coarse field is used when it is nonzero. When that field is zero, a 2-bit code selects one of four fixed levels. A wake-up source for line activity sits beside the identification logic. It pulls the interrupt line low but never appears in the identification vector, and only dropping its enable clears it. A configuration check flags a flow-control threshold that sits below the receive trigger.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: After reset, irqN is 1, iidVec is 0, wakePend is 0 and cfgErr is 0.
- R2: The effective RX trigger is rxTrigField*4 when rxTrigField is nonzero. Otherwise it is 8, 16, 32 or 56 for rxSelCode 0, 1, 2 or 3. The RX-threshold source is pending one clock after fifoEn=1 and rxLevel >= trigger hold, and it drops one clock after rxLevel falls below the trigger.
- R3: The TX trigger is derived from txTrigField and txSelCode by the same rule. The TX-threshold source is pending one clock after fifoEn=1 and txLevel <= trigger hold.
- R4: With fifoEn=0, or with the matching enable low, the threshold sources never assert irqN.
- R5: A txUnderrunEvt pulse makes the TX-status source pending. A resumeRead or an iidRead clears it. A set and a clear in the same cycle leave the source pending.
- R6: A txDoneEvt pulse makes the TX-status source pending. Only iidRead clears it, and resumeRead has no effect on it.
- R7: A statErrPush pulse makes the line-status source pending. It stays pending in every cycle where statFifoEmpty is 0 and clears one clock after statFifoEmpty is sampled 1.
- R8: An rxEofEvt pulse makes the end-of-frame source pending, and iidRead clears it.
- R9: iidVec is one-hot for the highest-priority pending enabled source, or 0 when no such source exists. The bit positions are: bit 0 RX threshold, bit 1 TX threshold, bit 5 TX status, bit 6 line status, bit 7 end-of-frame. The priority order, highest first, is line status, RX threshold, end-of-frame, TX status, TX threshold.
- R10: An activityPulse while wakeEn=1 sets wakePend and drives irqN low while iidVec stays unchanged. The flag holds until one clock after wakeEn is 0. A pulse while wakeEn=0 is ignored.
- R11: cfgErr is 1 one clock after flowEn=1 and flowTrigField*4 < effective RX trigger hold, and 0 otherwise.
- R12: Event sources latch even while their enable is low. irqN is 0 exactly when some pending source has its enable set, or when wakePend is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoEn | input | 1 | FIFO mode enable |
| rxSelCode | input | 2 | Fallback RX trigger code |
| txSelCode | input | 2 | Fallback TX trigger code |
| rxTrigField | input | 4 | Coarse RX trigger (units of 4) |
| txTrigField | input | 4 | Coarse TX trigger (units of 4) |
| flowEn | input | 1 | Hardware flow control enabled |
| flowTrigField | input | 4 | Flow-control threshold (units of 4) |
| ieRxThr | input | 1 | RX-threshold interrupt enable |
| ieTxThr | input | 1 | TX-threshold interrupt enable |
| ieTxStat | input | 1 | TX-status interrupt enable |
| ieLineStat | input | 1 | Line-status interrupt enable |
| ieRxEof | input | 1 | End-of-frame interrupt enable |
| rxLevel | input | CNT_W | RX FIFO occupancy |
| txLevel | input | CNT_W | TX FIFO occupancy |
| txUnderrunEvt | input | 1 | Holding register emptied before end-of-frame |
| txDoneEvt | input | 1 | Last frame bit sent without error |
| statErrPush | input | 1 | Error entry written into status FIFO |
| statFifoEmpty | input | 1 | Status FIFO is empty |
| rxEofEvt | input | 1 | End-of-frame received |
| resumeRead | input | 1 | Read strobe of the resume register |
| iidRead | input | 1 | Read strobe of the identification register |
| wakeEn | input | 1 | Wake-up enable |
| activityPulse | input | 1 | RX/CTS/DSR activity detected |
| irqN | output | 1 | Active-low interrupt |
| iidVec | output | 8 | One-hot identification of top source |
| wakePend | output | 1 | Wake-up event pending |
| cfgErr | output | 1 | Flow threshold below RX trigger |

## Verification
The bench keeps the default build: a 7-bit occupancy count (levels 0 to 64), a coarse-field granularity of 4, and fallback levels 8/16/32/56. This size lets the bench sweep every coarse value, every fallback code and every fill level for both directions, checking the crossing point of each trigger exactly. It also lets the bench cover the full flow-threshold against RX-trigger grid for the configuration check. Directed sequences cover the separate clear rules of the two TX-status causes, the hold of the line-status source, priority ordering and the wake-up path.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int IID_W    = 8;
  localparam int IID_RX   = 0;
  localparam int IID_TX   = 1;
  localparam int IID_TXST = 5;
  localparam int IID_LINE = 6;
  localparam int IID_EOF  = 7;

  typedef struct packed {
    logic setUnd;
    logic clrUnd;
    logic setDone;
    logic clrDone;
    logic setLine;
    logic clrLine;
    logic setEof;
    logic clrEof;
    logic setWake;
    logic clrWake;
  } uirqStrobe_t;

  typedef struct packed {
    logic rxThr;
    logic txThr;
    logic txUnd;
    logic txDone;
    logic line;
    logic eof;
    logic wake;
  } uirqFlags_t;
endpackage

// File: rtl/uirq_datapath.sv
module uirq_datapath
  import uirq_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int GRAN  = 4,
  parameter int LVL0  = 8,
  parameter int LVL1  = 16,
  parameter int LVL2  = 32,
  parameter int LVL3  = 56
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic [1:0]       rxSelCode,
  input  logic [1:0]       txSelCode,
  input  logic [3:0]       rxTrigField,
  input  logic [3:0]       txTrigField,
  input  logic             flowEn,
  input  logic [3:0]       flowTrigField,
  input  logic [CNT_W-1:0] rxLevel,
  input  logic [CNT_W-1:0] txLevel,
  input  logic             wakeEn,
  input  logic             statFifoEmpty,
  input  logic             resumeRead,
  input  logic             iidRead,
  input  uirqStrobe_t      strobe,
  output uirqFlags_t       flags,
  output logic             cfgErr
);
  localparam int NCH = 2;

  function automatic logic [CNT_W-1:0] pickTrig(input logic [3:0] fld, input logic [1:0] sel);
    int v;
    if (fld != 4'd0) v = int'(fld) * GRAN;
    else begin
      case (sel)
        2'd0:    v = LVL0;
        2'd1:    v = LVL1;
        2'd2:    v = LVL2;
        default: v = LVL3;
      endcase
    end
    return CNT_W'(v);
  endfunction

  logic [CNT_W-1:0] trigArr [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_trig
    logic [3:0] fld;
    logic [1:0] sel;
    assign fld = (ch == 0) ? rxTrigField : txTrigField;
    assign sel = (ch == 0) ? rxSelCode : txSelCode;
    assign trigArr[ch] = pickTrig(fld, sel);
  end

  logic rxHit, txHit, cfgNext;
  assign rxHit = fifoEn && (rxLevel >= trigArr[0]);
  assign txHit = fifoEn && (txLevel <= trigArr[1]);

  always_comb begin
    cfgNext = flowEn && ((int'(flowTrigField) * GRAN) < int'(trigArr[0]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags  <= '0;
      cfgErr <= 1'b0;
    end else begin
      flags.rxThr  <= rxHit;
      flags.txThr  <= txHit;
      flags.txUnd  <= strobe.setUnd  | (flags.txUnd  & ~strobe.clrUnd);
      flags.txDone <= strobe.setDone | (flags.txDone & ~strobe.clrDone);
      flags.line   <= strobe.setLine | (flags.line   & ~strobe.clrLine);
      flags.eof    <= strobe.setEof  | (flags.eof    & ~strobe.clrEof);
      flags.wake   <= ~strobe.clrWake & (strobe.setWake | flags.wake);
      cfgErr       <= cfgNext;
    end
  end

  AST_RX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |=> !flags.rxThr);  // R4
  AST_DONE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (flags.txDone && resumeRead && !iidRead) |=> flags.txDone);  // R6
  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (flags.line && !statFifoEmpty) |=> flags.line);  // R7
  AST_WAKE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !wakeEn |=> !flags.wake);  // R10
  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !flowEn |=> !cfgErr);  // R11
endmodule

// File: rtl/uirq_control.sv
module uirq_control
  import uirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ieRxThr,
  input  logic             ieTxThr,
  input  logic             ieTxStat,
  input  logic             ieLineStat,
  input  logic             ieRxEof,
  input  logic             txUnderrunEvt,
  input  logic             txDoneEvt,
  input  logic             statErrPush,
  input  logic             statFifoEmpty,
  input  logic             rxEofEvt,
  input  logic             resumeRead,
  input  logic             iidRead,
  input  logic             wakeEn,
  input  logic             activityPulse,
  input  uirqFlags_t       flags,
  output uirqStrobe_t      strobe,
  output logic [IID_W-1:0] iidVec,
  output logic             irqN
);
  always_comb begin
    strobe         = '0;
    strobe.setUnd  = txUnderrunEvt;
    strobe.clrUnd  = resumeRead | iidRead;
    strobe.setDone = txDoneEvt;
    strobe.clrDone = iidRead;
    strobe.setLine = statErrPush;
    strobe.clrLine = statFifoEmpty;
    strobe.setEof  = rxEofEvt;
    strobe.clrEof  = iidRead;
    strobe.setWake = wakeEn & activityPulse;
    strobe.clrWake = ~wakeEn;
  end

  logic onRx, onTx, onTxSt, onLine, onEof;
  assign onRx   = ieRxThr    & flags.rxThr;
  assign onTx   = ieTxThr    & flags.txThr;
  assign onTxSt = ieTxStat   & (flags.txUnd | flags.txDone);
  assign onLine = ieLineStat & flags.line;
  assign onEof  = ieRxEof    & flags.eof;

  always_comb begin
    iidVec = '0;
    if (onLine)      iidVec[IID_LINE] = 1'b1;
    else if (onRx)   iidVec[IID_RX]   = 1'b1;
    else if (onEof)  iidVec[IID_EOF]  = 1'b1;
    else if (onTxSt) iidVec[IID_TXST] = 1'b1;
    else if (onTx)   iidVec[IID_TX]   = 1'b1;
  end

  assign irqN = ~(onRx | onTx | onTxSt | onLine | onEof | flags.wake);

  AST_IID_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(iidVec));  // R9
  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (flags.line && ieLineStat) |-> iidVec[IID_LINE]);  // R9
  AST_WAKE_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    flags.wake |-> !irqN);  // R10
  AST_IID_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (iidVec != '0) |-> !irqN);  // R12
endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int GRAN  = 4,
  parameter int LVL0  = 8,
  parameter int LVL1  = 16,
  parameter int LVL2  = 32,
  parameter int LVL3  = 56
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic [1:0]       rxSelCode,
  input  logic [1:0]       txSelCode,
  input  logic [3:0]       rxTrigField,
  input  logic [3:0]       txTrigField,
  input  logic             flowEn,
  input  logic [3:0]       flowTrigField,
  input  logic             ieRxThr,
  input  logic             ieTxThr,
  input  logic             ieTxStat,
  input  logic             ieLineStat,
  input  logic             ieRxEof,
  input  logic [CNT_W-1:0] rxLevel,
  input  logic [CNT_W-1:0] txLevel,
  input  logic             txUnderrunEvt,
  input  logic             txDoneEvt,
  input  logic             statErrPush,
  input  logic             statFifoEmpty,
  input  logic             rxEofEvt,
  input  logic             resumeRead,
  input  logic             iidRead,
  input  logic             wakeEn,
  input  logic             activityPulse,
  output logic             irqN,
  output logic [7:0]       iidVec,
  output logic             wakePend,
  output logic             cfgErr
);
  uirqStrobe_t strobe;
  uirqFlags_t  flags;

  uirq_datapath #(
    .CNT_W(CNT_W), .GRAN(GRAN), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_dp (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn),
    .rxSelCode(rxSelCode), .txSelCode(txSelCode),
    .rxTrigField(rxTrigField), .txTrigField(txTrigField),
    .flowEn(flowEn), .flowTrigField(flowTrigField),
    .rxLevel(rxLevel), .txLevel(txLevel),
    .wakeEn(wakeEn), .statFifoEmpty(statFifoEmpty),
    .resumeRead(resumeRead), .iidRead(iidRead),
    .strobe(strobe), .flags(flags), .cfgErr(cfgErr)
  );

  uirq_control u_ctl (
    .clk(clk), .rstN(rstN),
    .ieRxThr(ieRxThr), .ieTxThr(ieTxThr), .ieTxStat(ieTxStat),
    .ieLineStat(ieLineStat), .ieRxEof(ieRxEof),
    .txUnderrunEvt(txUnderrunEvt), .txDoneEvt(txDoneEvt),
    .statErrPush(statErrPush), .statFifoEmpty(statFifoEmpty),
    .rxEofEvt(rxEofEvt), .resumeRead(resumeRead), .iidRead(iidRead),
    .wakeEn(wakeEn), .activityPulse(activityPulse),
    .flags(flags), .strobe(strobe), .iidVec(iidVec), .irqN(irqN)
  );

  assign wakePend = flags.wake;
endmodule

// File: tb/uart_fifo_irq_ctrl_tb.sv
module uart_fifo_irq_ctrl_tb;
  localparam int CNT_W = 7;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 0, flowEn = 0;
  logic [1:0] rxSelCode = 0, txSelCode = 0;
  logic [3:0] rxTrigField = 0, txTrigField = 0, flowTrigField = 0;
  logic ieRxThr = 0, ieTxThr = 0, ieTxStat = 0, ieLineStat = 0, ieRxEof = 0;
  logic [CNT_W-1:0] rxLevel = 0, txLevel = 0;
  logic txUnderrunEvt = 0, txDoneEvt = 0, statErrPush = 0, statFifoEmpty = 1;
  logic rxEofEvt = 0, resumeRead = 0, iidRead = 0, wakeEn = 0, activityPulse = 0;
  logic irqN, wakePend, cfgErr;
  logic [7:0] iidVec;
  int nChk = 0, nErr = 0;

  always #5 clk = ~clk;

  uart_fifo_irq_ctrl u_dut (.*);

  function automatic int expTrig(input int fld, input int sel);
    if (fld != 0) return fld * 4;
    case (sel)
      0: return 8;
      1: return 16;
      2: return 32;
      default: return 56;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    step(2);
    check("R1 irqN", irqN, 1);
    check("R1 iid", iidVec, 0);
    check("R1 wake", wakePend, 0);
    check("R1 cfg", cfgErr, 0);
    rstN = 1;
    step();

    // R2 RX trigger sweep
    fifoEn = 1; ieRxThr = 1; txLevel = 64;
    for (int f = 0; f < 16; f++)
      for (int s = 0; s < 4; s++)
        for (int l = 0; l <= 64; l++) begin
          rxTrigField = 4'(f); rxSelCode = 2'(s); rxLevel = 7'(l);
          step();
          check("R2 rx irqN", irqN, (l >= expTrig(f, s)) ? 0 : 1);
          check("R2 rx iid", iidVec, (l >= expTrig(f, s)) ? 1 : 0);
        end
    ieRxThr = 0; rxLevel = 0;

    // R3 TX trigger sweep
    ieTxThr = 1;
    for (int f = 0; f < 16; f++)
      for (int s = 0; s < 4; s++)
        for (int l = 0; l <= 64; l++) begin
          txTrigField = 4'(f); txSelCode = 2'(s); txLevel = 7'(l);
          step();
          check("R3 tx irqN", irqN, (l <= expTrig(f, s)) ? 0 : 1);
          check("R3 tx iid", iidVec, (l <= expTrig(f, s)) ? 2 : 0);
        end

    // R4 FIFO mode off / enable low
    txLevel = 0; rxLevel = 64; ieRxThr = 1; fifoEn = 0;
    step(2);
    check("R4 fifo off irqN", irqN, 1);
    fifoEn = 1; ieRxThr = 0; ieTxThr = 0;
    step(2);
    check("R4 enables low irqN", irqN, 1);
    fifoEn = 0; rxLevel = 0; txLevel = 64; rxTrigField = 0; txTrigField = 0;
    rxSelCode = 0; txSelCode = 0;
    step();

    // R5 underrun, resume clears
    ieTxStat = 1;
    txUnderrunEvt = 1; step(); txUnderrunEvt = 0;
    check("R5 underrun iid", iidVec, 32);
    step(3);
    check("R5 underrun held", iidVec, 32);
    resumeRead = 1; step(); resumeRead = 0;
    check("R5 resume clears", iidVec, 0);
    check("R5 resume irqN", irqN, 1);
    txUnderrunEvt = 1; step(); txUnderrunEvt = 0;
    iidRead = 1; step(); iidRead = 0;
    check("R5 iid read clears", iidVec, 0);
    txUnderrunEvt = 1; resumeRead = 1; step(); txUnderrunEvt = 0; resumeRead = 0;
    check("R5 set beats clear", iidVec, 32);
    iidRead = 1; step(); iidRead = 0;

    // R6 done, resume ignored
    txDoneEvt = 1; step(); txDoneEvt = 0;
    check("R6 done iid", iidVec, 32);
    resumeRead = 1; step(); resumeRead = 0;
    check("R6 resume ignored", iidVec, 32);
    iidRead = 1; step(); iidRead = 0;
    check("R6 iid read clears", iidVec, 0);

    // R7 line status held until empty
    ieLineStat = 1; statFifoEmpty = 0; statErrPush = 1; step(); statErrPush = 0;
    check("R7 line iid", iidVec, 64);
    iidRead = 1; step(3); iidRead = 0;
    check("R7 line held", iidVec, 64);
    statFifoEmpty = 1; step();
    check("R7 line cleared", iidVec, 0);

    // R8 end-of-frame
    ieRxEof = 1; rxEofEvt = 1; step(); rxEofEvt = 0;
    check("R8 eof iid", iidVec, 128);
    step(2);
    check("R8 eof held", iidVec, 128);
    iidRead = 1; step(); iidRead = 0;
    check("R8 eof cleared", iidVec, 0);

    // R9 priority ordering
    fifoEn = 1; ieRxThr = 1; ieTxThr = 1; rxLevel = 64; txLevel = 0;
    statFifoEmpty = 0; statErrPush = 1; rxEofEvt = 1; txUnderrunEvt = 1;
    step(); statErrPush = 0; rxEofEvt = 0; txUnderrunEvt = 0;
    check("R9 line first", iidVec, 64);
    statFifoEmpty = 1; step();
    check("R9 rx second", iidVec, 1);
    rxLevel = 0; step();
    check("R9 eof third", iidVec, 128);
    iidRead = 1; step(); iidRead = 0;
    check("R9 tx thr last", iidVec, 2);
    txUnderrunEvt = 1; step(); txUnderrunEvt = 0;
    check("R9 tx status over tx thr", iidVec, 32);
    resumeRead = 1; step(); resumeRead = 0;
    check("R9 back to tx thr", iidVec, 2);
    txLevel = 64; step();
    check("R9 none", iidVec, 0);

    // R12 disabled source still latches
    ieRxEof = 0; rxEofEvt = 1; step(); rxEofEvt = 0;
    check("R12 disabled irqN", irqN, 1);
    check("R12 disabled iid", iidVec, 0);
    ieRxEof = 1; #1;
    check("R12 latched shows", iidVec, 128);
    check("R12 latched irqN", irqN, 0);
    iidRead = 1; step(); iidRead = 0;
    check("R12 cleared irqN", irqN, 1);

    // R10 wake-up
    activityPulse = 1; step(); activityPulse = 0;
    check("R10 ignored when off", wakePend, 0);
    check("R10 ignored irqN", irqN, 1);
    wakeEn = 1; step();
    activityPulse = 1; step(); activityPulse = 0;
    check("R10 wake set", wakePend, 1);
    check("R10 wake irqN", irqN, 0);
    check("R10 iid untouched", iidVec, 0);
    iidRead = 1; resumeRead = 1; step(3); iidRead = 0; resumeRead = 0;
    check("R10 wake held", wakePend, 1);
    wakeEn = 0; step();
    check("R10 wake cleared", wakePend, 0);
    check("R10 irqN released", irqN, 1);

    // R11 configuration check sweep
    for (int e = 0; e < 2; e++)
      for (int ft = 0; ft < 16; ft++)
        for (int f = 0; f < 16; f++)
          for (int s = 0; s < 4; s++) begin
            flowEn = e[0]; flowTrigField = 4'(ft); rxTrigField = 4'(f); rxSelCode = 2'(s);
            step();
            check("R11 cfgErr", cfgErr, (e == 1 && ft * 4 < expTrig(f, s)) ? 1 : 0);
          end

    finishRun();
  end
endmodule